// File: doc/BRIEF.md
# Debug Clock Handshake Synchronizer

This block lets an external debug probe, running its own test clock with no fixed relation to the core clock, drive debug activity inside a core that has only one clock. The probe's test clock passes through a three-flop synchronizer on the core clock. A rising edge seen at the synchronizer output produces a clock enable that lasts exactly one core cycle. Debug logic downstream advances only on core cycles where this enable is high. The mode-select and data-in serial lines are captured into hold registers on the same enable, so the debug logic always sees values that are stable and sampled in the core domain.

The synchronized test clock is also sent back to the probe as a returned clock. A probe that waits for the returned clock to follow each of its test-clock edges before it moves on is throttled to whatever rate the core clock can support, and no edge is ever lost. The serial data-out line from the debug logic goes straight back to the probe pad.

Top module: `jtag_adaptive_sync`

## Requirements
- R1: While rst_n is low, rtck, dbg_tck_en, dbg_tms and dbg_tdi are all 0, whatever the pads carry.
- R2: rtck equals tck_pad delayed by three rising clk edges. A tck_pad change made between edges shows on rtck just after the third following edge.
- R3: Each rising edge of tck_pad gives exactly one dbg_tck_en pulse. The pulse is one clk cycle long and is high between the second and third clk edges after the change. A falling edge of tck_pad gives no pulse.
- R4: At the clk edge that ends a dbg_tck_en pulse, dbg_tms takes the value of tms_pad and dbg_tdi takes the value of tdi_pad. This is the same edge at which rtck rises.
- R5: When dbg_tck_en is low, dbg_tms and dbg_tdi keep their values, even if tms_pad and tdi_pad change.
- R6: tdo_pad always equals dbg_tdo, with no register in between.
- R7: When the probe waits for rtck before each tck_pad change, and tck_pad changes at random phase against clk, the number of dbg_tck_en pulses equals the number of tck_pad rising edges. No pulse is lost and none is duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| tck_pad | input | 1 | Asynchronous test clock from the probe |
| tms_pad | input | 1 | Mode-select serial line from the probe |
| tdi_pad | input | 1 | Serial data from the probe |
| dbg_tdo | input | 1 | Serial data out of the core's debug logic |
| rtck | output | 1 | Returned test clock to the probe |
| tdo_pad | output | 1 | Serial data to the probe |
| dbg_tck_en | output | 1 | One-cycle debug clock enable |
| dbg_tms | output | 1 | Held mode-select value |
| dbg_tdi | output | 1 | Held data-in value |

## Verification
A wrong synchronizer stage changes the timing of rtck within three cycles of a test-clock edge. Because the probe waits for rtck, the same fault also shows as a stalled handshake. A wrong edge detector shows up as an extra or missing enable pulse on the very next edge of either polarity. The scoreboard finds it when the pulse count no longer matches the count of rising edges. A fault in a hold register shows at the edge that ends an enable pulse, as a captured bit that differs from the value the probe presented. If the fault leaks between pulses instead, it shows within one cycle of a pad change.

// File: rtl/jas_pkg.sv
package jas_pkg;
  localparam int SYNC_STAGES = 3;
  localparam int HOLD_W      = 2;

  typedef struct packed {
    logic tms;
    logic tdi;
  } dbg_bits_t;

  // rising edge of a synchronized level: newer stage high, older stage low
  function automatic logic rise_of(input logic newer, input logic older);
    return newer & ~older;
  endfunction
endpackage

// File: rtl/jas_sync_chain.sv
module jas_sync_chain #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_async,
  output logic [STAGES-1:0] q
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[g] <= 1'b0;
        else        q[g] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[g] <= 1'b0;
        else        q[g] <= q[g-1];
      end
    end
  end
endmodule

// File: rtl/jas_edge_pulse.sv
module jas_edge_pulse
  import jas_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_new,
  input  logic lvl_old,
  output logic pulse
);
  assign pulse = rise_of(lvl_new, lvl_old);

  p_single_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse)
    else $error("enable pulse longer than one cycle");
endmodule

// File: rtl/jas_hold_reg.sv
module jas_hold_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (q == $past(d)))
    else $error("hold register missed capture");

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q))
    else $error("hold register changed without enable");
endmodule

// File: rtl/jtag_adaptive_sync.sv
module jtag_adaptive_sync
  import jas_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tck_pad,
  input  logic tms_pad,
  input  logic tdi_pad,
  input  logic dbg_tdo,
  output logic rtck,
  output logic tdo_pad,
  output logic dbg_tck_en,
  output logic dbg_tms,
  output logic dbg_tdi
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] tck_sync;
  dbg_bits_t              pad_bits;
  dbg_bits_t              held_bits;
  logic                   rise_evt;

  jas_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (tck_pad),
    .q       (tck_sync)
  );

  jas_edge_pulse u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_new (tck_sync[LAST-1]),
    .lvl_old (tck_sync[LAST]),
    .pulse   (rise_evt)
  );

  assign pad_bits.tms = tms_pad;
  assign pad_bits.tdi = tdi_pad;

  jas_hold_reg #(.W(HOLD_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (rise_evt),
    .d     (pad_bits),
    .q     (held_bits)
  );

  assign rtck       = tck_sync[LAST];
  assign dbg_tck_en = rise_evt;
  assign dbg_tms    = held_bits.tms;
  assign dbg_tdi    = held_bits.tdi;
  assign tdo_pad    = dbg_tdo;

  p_rtck_after_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtck) |-> $past(dbg_tck_en))
    else $error("returned clock rose without a preceding enable");

  p_no_pulse_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rtck) |-> !$past(dbg_tck_en))
    else $error("enable pulse around a falling edge");
endmodule

// File: tb/jtag_adaptive_sync_tb.sv
`timescale 1ns/10ps
module jtag_adaptive_sync_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tck_pad = 1'b0, tms_pad = 1'b0, tdi_pad = 1'b0, dbg_tdo = 1'b0;
  logic rtck, tdo_pad, dbg_tck_en, dbg_tms, dbg_tdi;

  int total = 0;
  int bad = 0;
  int rises = 0;
  int pulses = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  logic [1:0] exp_q[$];

  always #2.5 clk = ~clk;

  jtag_adaptive_sync dut_i (
    .clk(clk), .rst_n(rst_n), .tck_pad(tck_pad), .tms_pad(tms_pad),
    .tdi_pad(tdi_pad), .dbg_tdo(dbg_tdo), .rtck(rtck), .tdo_pad(tdo_pad),
    .dbg_tck_en(dbg_tck_en), .dbg_tms(dbg_tms), .dbg_tdi(dbg_tdi)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: present data, raise tck, push the expected capture
  task automatic raise_tck(input logic t, input logic d);
    tms_pad = t;
    tdi_pad = d;
    exp_q.push_back({t, d});
    rises++;
    tck_pad = 1'b1;
  endtask

  task automatic random_phase();
    @(negedge clk);
    #($urandom_range(3, 243) * 0.01);
  endtask

  // monitor: every enable pulse pops one expected item
  initial begin
    logic prev_en;
    prev_en = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_on && dbg_tck_en) begin
        logic [1:0] e;
        pulses++;
        check(!prev_en, "R3", "pulse wider than one cycle", 1, 0);
        prev_en = 1'b1;
        @(posedge clk);
        #0.5;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "pulse with no rising edge", pulses, rises);
        end else begin
          e = exp_q.pop_front();
          check(dbg_tms == e[1], "R4", "captured tms", dbg_tms, e[1]);
          check(dbg_tdi == e[0], "R4", "captured tdi", dbg_tdi, e[0]);
        end
      end else begin
        prev_en = 1'b0;
      end
    end
  end

  initial begin
    #(200000 * 5);
    check(1'b0, "WATCHDOG", "run hung", 0, 1);
    finish_run();
  end

  initial begin
    // R1: reset holds outputs low while pads are active
    tck_pad = 1'b1; tms_pad = 1'b1; tdi_pad = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(rtck == 1'b0, "R1", "rtck in reset", rtck, 0);
    check(dbg_tck_en == 1'b0, "R1", "enable in reset", dbg_tck_en, 0);
    check(dbg_tms == 1'b0, "R1", "tms in reset", dbg_tms, 0);
    check(dbg_tdi == 1'b0, "R1", "tdi in reset", dbg_tdi, 0);
    tck_pad = 1'b0; tms_pad = 1'b0; tdi_pad = 1'b0;
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (4) @(posedge clk);

    // R2/R3/R4: exact latency of one rising edge
    @(negedge clk); #0.3;
    raise_tck(1'b1, 1'b0);
    @(posedge clk); #0.5;
    check(dbg_tck_en == 1'b0, "R3", "enable after edge 1", dbg_tck_en, 0);
    check(rtck == 1'b0, "R2", "rtck after edge 1", rtck, 0);
    @(posedge clk); #0.5;
    check(dbg_tck_en == 1'b1, "R3", "enable after edge 2", dbg_tck_en, 1);
    check(rtck == 1'b0, "R2", "rtck after edge 2", rtck, 0);
    @(posedge clk); #0.5;
    check(rtck == 1'b1, "R2", "rtck after edge 3", rtck, 1);
    check(dbg_tck_en == 1'b0, "R3", "enable after edge 3", dbg_tck_en, 0);
    check(dbg_tms == 1'b1 && dbg_tdi == 1'b0, "R4", "capture at rtck rise",
          {dbg_tms, dbg_tdi}, 2);

    // R5: pads toggle while tck stays high, held values stay put
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tms_pad = i[0]; tdi_pad = ~i[0];
      @(posedge clk); #0.5;
      check(dbg_tms == 1'b1 && dbg_tdi == 1'b0, "R5", "hold while idle",
            {dbg_tms, dbg_tdi}, 2);
    end

    // R3: falling edge gives no pulse, rtck follows after three edges
    @(negedge clk); #0.3;
    tck_pad = 1'b0;
    for (int i = 1; i <= 3; i++) begin
      @(posedge clk); #0.5;
      check(dbg_tck_en == 1'b0, "R3", "no pulse on fall", dbg_tck_en, 0);
      if (i < 3) check(rtck == 1'b1, "R2", "rtck before fall latency", rtck, 1);
    end
    check(rtck == 1'b0, "R2", "rtck after fall", rtck, 0);
    check(dbg_tms == 1'b1 && dbg_tdi == 1'b0, "R5", "hold across fall",
          {dbg_tms, dbg_tdi}, 2);

    // R6: data-out path is combinational
    dbg_tdo = 1'b1; #0.2;
    check(tdo_pad == 1'b1, "R6", "tdo high", tdo_pad, 1);
    dbg_tdo = 1'b0; #0.2;
    check(tdo_pad == 1'b0, "R6", "tdo low", tdo_pad, 0);

    // R7: handshaking probe at random phase against clk
    for (int n = 0; n < 400; n++) begin
      random_phase();
      raise_tck(1'($urandom), 1'($urandom));
      wait (rtck == 1'b1);
      repeat ($urandom_range(0, 3)) @(posedge clk);
      random_phase();
      tms_pad = 1'($urandom); tdi_pad = 1'($urandom);
      tck_pad = 1'b0;
      wait (rtck == 1'b0);
      repeat ($urandom_range(0, 3)) @(posedge clk);
    end

    repeat (10) @(posedge clk);
    #0.5;
    check(pulses == rises, "R7", "pulse count vs rising edges", pulses, rises);
    check(exp_q.size() == 0, "R7", "edges left without a pulse", exp_q.size(), 0);
    finish_run();
  end
endmodule